// File: doc/BRIEF.md
# Register-Mapped Multiply-Divide Coprocessor

This block is an arithmetic helper that sits on a small CPU's register bus. Software writes 16-bit operands into a handful of word registers, picks a mode in an 8-bit control register, and reads the answer back from the same register file. Three modes share one set of registers: a single 16x16 unsigned product, a 16x16 product summed into a 32-bit accumulator, and a 32-by-32 unsigned division that returns both quotient and remainder.

Multiplication is launched by writing the high operand word. The product appears in the result register pair on the next clock edge. In accumulate mode the same product is added into the accumulator one edge later. Division is started from the control register. It takes a fixed 16 cycles and retires two quotient bits per cycle. While it runs, the start bit reads back as 1 and the operand registers are locked. When enabled, a one-cycle pulse marks completion.

Top module: `mdu_top`

## Requirements
- R1: After reset every register reads 0 and `done_o` is low.
- R2: The byte address map is opA_lo 0x00, opA_hi 0x02, res_hi 0x04, res_lo 0x06, acc_lo 0x10, acc_hi 0x12 and control 0x18. The control register sits in bits 7:0 of the data word. Only control bits 7 (divide), 6 (accumulate), 3 (pulse enable) and 0 (go/busy) are stored; the other control bits and every unmapped address read 0.
- R3: With control bits 7:6 = 00, a write to opA_hi loads {res_hi,res_lo} = opA_lo*opA_hi on the next clock edge.
- R4: With control bits 7:6 = 01, a write to opA_hi loads the product into {res_hi,res_lo} on the next edge. On the edge after that, it adds the product into {acc_hi,acc_lo}, wrapping modulo 2^32. The accumulator can be preloaded by bus writes, and each opA_hi write accumulates once.
- R5: A control write with bits 7 and 0 both set starts a division. Bit 0 then reads 1 for exactly 16 cycles and 0 afterwards.
- R6: On completion {opA_hi,opA_lo} holds the quotient of the 32-bit dividend {opA_hi,opA_lo} by the divisor {res_hi,res_lo}, {acc_hi,acc_lo} holds the remainder, and the divisor registers are unchanged.
- R7: A zero divisor yields quotient 0xFFFFFFFF and a remainder equal to the dividend.
- R8: While bit 0 is set, bus writes to operand, accumulator and control registers are ignored.
- R9: If control bit 3 is set, `done_o` is high for exactly the one cycle after bit 0 clears. If bit 3 is clear, `done_o` stays low.
- R10: With control bit 7 set, a write to opA_hi launches no multiply, so the result registers keep their value.
- R11: Writing bit 0 without bit 7 starts nothing, and bit 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| addr_i | input | 5 | byte address of the register |
| we_i | input | 1 | write strobe |
| re_i | input | 1 | read strobe |
| wdata_i | input | 16 | write data |
| rdata_o | output | 16 | read data, combinational from register state, 0 when `re_i` is low |
| done_o | output | 1 | division completion pulse |

## Verification
Reads are combinational, so a register is sampled in the same cycle that the bench presents its address. All timing is therefore counted in edges after the edge that takes the write.

- The product is due one edge after the opA_hi write, so the bench leaves exactly one idle cycle before reading the result pair.
- The accumulator is due two edges after the opA_hi write, so the bench leaves exactly two idle cycles before reading it.
- After the edge that takes a go write, the bench polls control once per cycle. It expects 16 busy reads, then a clear read in the same cycle as the completion pulse, and then reads the quotient, remainder and divisor against values it computes arithmetically.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] ADR_A_LO = 5'h00;
  localparam logic [ADDR_W-1:0] ADR_A_HI = 5'h02;
  localparam logic [ADDR_W-1:0] ADR_B_HI = 5'h04;
  localparam logic [ADDR_W-1:0] ADR_B_LO = 5'h06;
  localparam logic [ADDR_W-1:0] ADR_C_LO = 5'h10;
  localparam logic [ADDR_W-1:0] ADR_C_HI = 5'h12;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 5'h18;

  localparam int CTRL_W = 8;
  localparam int CB_DIV = 7;
  localparam int CB_MAC = 6;
  localparam int CB_IRQ = 3;
  localparam int CB_GO  = 0;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 8'hC9;
endpackage

// File: rtl/mdu_mac.sv
module mdu_mac #(
  parameter int W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           launch_i,
  input  logic           mac_i,
  input  logic [W-1:0]   op_lo_i,
  input  logic [W-1:0]   op_hi_i,
  input  logic [2*W-1:0] prod_fb_i,
  input  logic [2*W-1:0] acc_i,
  output logic           prod_we_o,
  output logic [2*W-1:0] prod_o,
  output logic           acc_we_o,
  output logic [2*W-1:0] acc_o
);
  localparam int PW = 2 * W;

  logic launch_q, mac_q, acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      launch_q <= 1'b0;
      mac_q    <= 1'b0;
      acc_q    <= 1'b0;
    end else begin
      launch_q <= launch_i;
      mac_q    <= mac_i;
      acc_q    <= launch_q & mac_q;
    end
  end

  // product lands in the result pair first; accumulate reads it back one edge later
  assign prod_we_o = launch_q;
  assign prod_o    = PW'(op_lo_i) * PW'(op_hi_i);
  assign acc_we_o  = acc_q;
  assign acc_o     = acc_i + prod_fb_i;

  assert_acc_after_prod_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_we_o |-> $past(prod_we_o));
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         fin_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  localparam int STEPS = W / 2;
  localparam int CW    = $clog2(STEPS + 1);
  localparam int PW    = W + 2;

  logic [W-1:0]  q_q, d_q, r_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [PW-1:0] part, rem_n;
  logic [PW-1:0] mult [4];
  logic [3:1]    ge;
  logic [1:0]    digit;

  assign part    = {r_q, q_q[W-1 -: 2]};
  assign mult[0] = '0;

  for (genvar k = 1; k < 4; k++) begin : g_mult
    assign mult[k] = PW'(d_q) * PW'(k);
    assign ge[k]   = part >= mult[k];
  end

  // radix-4 restoring step: largest multiple not above the partial remainder
  always_comb begin
    if (ge[3])      digit = 2'd3;
    else if (ge[2]) digit = 2'd2;
    else if (ge[1]) digit = 2'd1;
    else            digit = 2'd0;
    rem_n = part - mult[digit];
  end

  assign quot_o = {q_q[W-3:0], digit};
  assign rem_o  = rem_n[W-1:0];
  assign fin_o  = busy_q && (cnt_q == CW'(1));
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= '0;
      d_q    <= '0;
      r_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      q_q    <= dividend_i;
      d_q    <= divisor_i;
      r_q    <= '0;
      cnt_q  <= CW'(STEPS);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      q_q   <= quot_o;
      r_q   <= rem_o;
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) busy_q <= 1'b0;
    end
  end

  assert_cnt_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q != '0) && (cnt_q <= CW'(STEPS)));
  assert_fin_ends_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o && !start_i |=> !busy_o);
endmodule

// File: rtl/mdu_top.sv
module mdu_top
  import mdu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              done_o
);
  localparam int LW = 2 * DW;

  logic [DW-1:0]     a_lo_q, a_hi_q, b_lo_q, b_hi_q, c_lo_q, c_hi_q;
  logic [CTRL_W-1:0] ctrl_q, ctrl_n;
  logic              done_q;
  logic              busy, launch, start;
  logic              prod_we, acc_we;
  logic [LW-1:0]     prod, acc;
  logic              div_busy, div_fin;
  logic [LW-1:0]     quot, rem;

  assign busy   = ctrl_q[CB_GO];
  assign launch = we_i && !busy && (addr_i == ADR_A_HI) && !ctrl_q[CB_DIV];
  assign start  = we_i && !busy && (addr_i == ADR_CTRL) && wdata_i[CB_DIV] && wdata_i[CB_GO];

  always_comb begin
    ctrl_n        = wdata_i[CTRL_W-1:0] & CTRL_MASK;
    ctrl_n[CB_GO] = wdata_i[CB_DIV] & wdata_i[CB_GO];
  end

  mdu_mac #(.W(DW)) u_mac (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch),
    .mac_i     (ctrl_q[CB_MAC]),
    .op_lo_i   (a_lo_q),
    .op_hi_i   (a_hi_q),
    .prod_fb_i ({b_hi_q, b_lo_q}),
    .acc_i     ({c_hi_q, c_lo_q}),
    .prod_we_o (prod_we),
    .prod_o    (prod),
    .acc_we_o  (acc_we),
    .acc_o     (acc)
  );

  mdu_div #(.W(LW)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .dividend_i ({a_hi_q, a_lo_q}),
    .divisor_i  ({b_hi_q, b_lo_q}),
    .busy_o     (div_busy),
    .fin_o      (div_fin),
    .quot_o     (quot),
    .rem_o      (rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_lo_q <= '0;
      a_hi_q <= '0;
      b_lo_q <= '0;
      b_hi_q <= '0;
      c_lo_q <= '0;
      c_hi_q <= '0;
      ctrl_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (we_i && !busy) begin
        unique case (addr_i)
          ADR_A_LO: a_lo_q <= wdata_i;
          ADR_A_HI: a_hi_q <= wdata_i;
          ADR_B_HI: b_hi_q <= wdata_i;
          ADR_B_LO: b_lo_q <= wdata_i;
          ADR_C_LO: c_lo_q <= wdata_i;
          ADR_C_HI: c_hi_q <= wdata_i;
          ADR_CTRL: ctrl_q <= ctrl_n;
          default: ;
        endcase
      end
      // engine results take precedence over a same-edge bus write
      if (prod_we) {b_hi_q, b_lo_q} <= prod;
      if (acc_we)  {c_hi_q, c_lo_q} <= acc;
      if (div_fin) begin
        {a_hi_q, a_lo_q} <= quot;
        {c_hi_q, c_lo_q} <= rem;
        ctrl_q[CB_GO]    <= 1'b0;
      end
      done_q <= div_fin & ctrl_q[CB_IRQ];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      unique case (addr_i)
        ADR_A_LO: rdata_o = a_lo_q;
        ADR_A_HI: rdata_o = a_hi_q;
        ADR_B_HI: rdata_o = b_hi_q;
        ADR_B_LO: rdata_o = b_lo_q;
        ADR_C_LO: rdata_o = c_lo_q;
        ADR_C_HI: rdata_o = c_hi_q;
        ADR_CTRL: rdata_o = DW'(ctrl_q);
        default:  rdata_o = '0;
      endcase
    end
  end

  assign done_o = done_q;

  assert_go_tracks_engine_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy == div_busy);
  assert_go_clear_by_fin_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_q[CB_GO]) |-> $past(div_fin));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ctrl_q[CB_GO] && $past(ctrl_q[CB_GO]));
  assert_divisor_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[CB_GO] && $past(ctrl_q[CB_GO]) |-> $stable({b_hi_q, b_lo_q}));
  assert_no_mul_in_div_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prod_we |-> !$past(ctrl_q[CB_DIV]));
endmodule

// File: tb/mdu_top_tb_top.sv
module mdu_top_tb_top;
  import mdu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic        done;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  mdu_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .re_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .done_o(done)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v, output logic dn);
    addr = a; re = 1'b1;
    #1;
    v = rdata; dn = done;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic rd32(input logic [4:0] lo, input logic [4:0] hi, output logic [31:0] v);
    logic [15:0] l, h;
    logic dn;
    rd(lo, l, dn);
    rd(hi, h, dn);
    v = {h, l};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_div(input logic [31:0] a, input logic [31:0] b, input logic [15:0] go);
    wr(ADR_CTRL, 16'h00C0);
    wr(ADR_A_LO, a[15:0]);
    wr(ADR_A_HI, a[31:16]);
    wr(ADR_B_HI, b[31:16]);
    wr(ADR_B_LO, b[15:0]);
    wr(ADR_CTRL, go);
  endtask

  task automatic check_div_results(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] q, r, bb, eq, er;
    eq = (b == 0) ? 32'hFFFF_FFFF : a / b;
    er = (b == 0) ? a : a % b;
    rd32(ADR_A_LO, ADR_A_HI, q);
    rd32(ADR_C_LO, ADR_C_HI, r);
    rd32(ADR_B_LO, ADR_B_HI, bb);
    chk((b == 0) ? "R7 quotient div0" : "R6 quotient", q, eq);
    chk((b == 0) ? "R7 remainder div0" : "R6 remainder", r, er);
    chk("R6 divisor kept", bb, b);
  endtask

  task automatic do_div(input logic [31:0] a, input logic [31:0] b, input bit irq);
    logic [15:0] v;
    logic dn;
    bit busy_ok, done_ok;
    load_div(a, b, irq ? 16'h00C9 : 16'h00C1);
    busy_ok = 1'b1; done_ok = 1'b1;
    for (int i = 0; i < 17; i++) begin
      rd(ADR_CTRL, v, dn);
      if (i < 16) begin
        if (v[0] !== 1'b1) busy_ok = 1'b0;
        if (dn !== 1'b0) done_ok = 1'b0;
      end else begin
        if (v[0] !== 1'b0) busy_ok = 1'b0;
        if (dn !== irq) done_ok = 1'b0;
      end
    end
    chk("R5 busy window 16 cycles", 32'(busy_ok), 32'd1);
    chk("R9 done pulse", 32'(done_ok), 32'd1);
    check_div_results(a, b);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic dn;
    logic [31:0] x32, acc_exp;
    logic [15:0] mv [8];
    logic [31:0] dv [8];
    logic [31:0] sv [8];
    mv = '{16'h0000, 16'h0001, 16'h0002, 16'h00FF, 16'h1234, 16'h8000, 16'hFFFE, 16'hFFFF};
    dv = '{32'h0, 32'h1, 32'h7, 32'd100, 32'h1234_5678, 32'h8000_0000, 32'hFFFF_FFFF, 32'hDEAD_BEEF};
    sv = '{32'h0, 32'h1, 32'h2, 32'h3, 32'h7, 32'h0001_0000, 32'h8000_0001, 32'hFFFF_FFFF};

    idle(2);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    foreach (sv[i]) begin end
    rd(ADR_A_LO, v, dn); chk("R1 reset opA_lo", 32'(v), 0);
    rd(ADR_A_HI, v, dn); chk("R1 reset opA_hi", 32'(v), 0);
    rd(ADR_B_HI, v, dn); chk("R1 reset res_hi", 32'(v), 0);
    rd(ADR_B_LO, v, dn); chk("R1 reset res_lo", 32'(v), 0);
    rd(ADR_C_LO, v, dn); chk("R1 reset acc_lo", 32'(v), 0);
    rd(ADR_C_HI, v, dn); chk("R1 reset acc_hi", 32'(v), 0);
    rd(ADR_CTRL, v, dn); chk("R1 reset ctrl", 32'(v), 0);
    chk("R1 reset done", 32'(dn), 0);

    // R2 map, R10 no launch in divide mode
    wr(ADR_CTRL, 16'h00C0);
    wr(ADR_A_LO, 16'h1111);
    wr(ADR_A_HI, 16'h2222);
    wr(ADR_B_HI, 16'h3333);
    wr(ADR_B_LO, 16'h4444);
    wr(ADR_C_LO, 16'h5555);
    wr(ADR_C_HI, 16'h6666);
    idle(2);
    rd(ADR_A_LO, v, dn); chk("R2 opA_lo", 32'(v), 32'h1111);
    rd(ADR_A_HI, v, dn); chk("R2 opA_hi", 32'(v), 32'h2222);
    rd(ADR_B_HI, v, dn); chk("R2 R10 res_hi kept", 32'(v), 32'h3333);
    rd(ADR_B_LO, v, dn); chk("R2 R10 res_lo kept", 32'(v), 32'h4444);
    rd(ADR_C_LO, v, dn); chk("R2 acc_lo", 32'(v), 32'h5555);
    rd(ADR_C_HI, v, dn); chk("R2 acc_hi", 32'(v), 32'h6666);
    rd(5'h08, v, dn);    chk("R2 unmapped", 32'(v), 0);
    wr(ADR_CTRL, 16'hFF7E);
    rd(ADR_CTRL, v, dn); chk("R2 ctrl masked", 32'(v), 32'h0048);
    wr(ADR_CTRL, 16'h0001);
    idle(1);
    rd(ADR_CTRL, v, dn); chk("R11 go without divide", 32'(v), 0);

    // R3 plain multiply sweep
    wr(ADR_CTRL, 16'h0000);
    foreach (mv[i]) begin
      foreach (mv[j]) begin
        wr(ADR_A_LO, mv[i]);
        wr(ADR_A_HI, mv[j]);
        idle(1);
        rd32(ADR_B_LO, ADR_B_HI, x32);
        chk("R3 product", x32, 32'(mv[i]) * 32'(mv[j]));
      end
    end

    // R4 accumulate with preload and wrap
    wr(ADR_CTRL, 16'h0040);
    wr(ADR_C_LO, 16'hFFF0);
    wr(ADR_C_HI, 16'hFFFF);
    acc_exp = 32'hFFFF_FFF0;
    foreach (mv[i]) begin
      wr(ADR_A_LO, mv[i]);
      wr(ADR_A_HI, mv[7 - i]);
      idle(2);
      acc_exp = acc_exp + 32'(mv[i]) * 32'(mv[7 - i]);
      rd32(ADR_C_LO, ADR_C_HI, x32);
      chk("R4 accumulate", x32, acc_exp);
      rd32(ADR_B_LO, ADR_B_HI, x32);
      chk("R4 product reg", x32, 32'(mv[i]) * 32'(mv[7 - i]));
    end
    wr(ADR_A_LO, 16'h0005);
    wr(ADR_A_HI, 16'h0003);
    wr(ADR_A_HI, 16'h0003);
    idle(2);
    acc_exp = acc_exp + 32'd30;
    rd32(ADR_C_LO, ADR_C_HI, x32);
    chk("R4 back-to-back accumulate", x32, acc_exp);

    // R5 R6 R7 R9 divide sweep
    foreach (dv[i]) begin
      foreach (sv[j]) begin
        do_div(dv[i], sv[j], ((i + j) % 2) == 0);
      end
    end

    // R8 writes while busy ignored
    load_div(32'd1000, 32'd7, 16'h00C1);
    wr(ADR_A_LO, 16'hAAAA);
    wr(ADR_B_LO, 16'h5555);
    wr(ADR_C_HI, 16'h7777);
    wr(ADR_CTRL, 16'h0000);
    for (int k = 0; k < 20; k++) begin
      rd(ADR_CTRL, v, dn);
      if (v[0] == 1'b0) break;
    end
    chk("R8 ctrl write ignored", 32'(v), 32'h00C0);
    check_div_results(32'd1000, 32'd7);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule